// File: doc/BRIEF.md
# Memory-Write Request Parser for a 64-bit Transaction Stream

This block sits on the receive side of a PCIe transaction layer. Packets come in as 64-bit beats, each with a valid strobe, start and end markers and eight byte enables. The parser works out whether each packet is a memory write. A write can have a three-dword header with a 32-bit address or a four-dword header with a 64-bit address. For a write, the block presents the request's address, length, requester ID, tag and the two byte-enable nibbles. Then it sends on the payload dwords in arrival order, one strobe per 32-bit lane.

Any other kind of packet is read in up to its end marker and thrown away, and the drop is reported on a strobe. The payload is not realigned. Where the first dword lands inside a beat depends on the header size and on bit 2 of the address, so downstream logic takes lane 0 before lane 1 within each output beat.

Top module: `tlp_mwr_parser`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it is released, `hdr_valid_o`, `pl_dv_o`, `err_o` and `drop_o` are all zero.
- R2: Header dword 0 is in `data_i[31:0]` and header dword 1 is in `data_i[63:32]` of the start beat. The type byte is dword0[31:24], and 0x40 or 0x60 marks a memory write. The length is dword0[9:0]. In dword 1, the requester ID is [31:16], the tag is [15:8], the last-dword byte enables are [7:4] and the first-dword byte enables are [3:0]. `hdr_valid_o` pulses for one cycle, one cycle after the second beat, and the field outputs then hold these values.
- R3: For type 0x40, `addr_o` is {32 zero bits, second beat [31:2], 2'b00}. The two low address bits are forced to zero.
- R4: For type 0x40 with address bit 2 clear, the upper half of the second beat carries no payload, and the first payload dword is lane 0 (`data_i[31:0]`) of the third beat.
- R5: For type 0x40 with address bit 2 set, the first payload dword is `data_i[63:32]` of the second beat. It comes out on lane 1 together with `hdr_valid_o`.
- R6: For type 0x60, the second beat carries address bits [63:32] in `data_i[31:0]` and bits [31:0] in `data_i[63:32]`. Bits [1:0] are forced to zero, and the payload starts in lane 0 of the third beat.
- R7: Exactly as many payload lanes are strobed as the length says, with a length field of 0 meaning 1024 dwords. Lanes beyond the declared length are not strobed.
- R8: A payload lane whose four byte enables are all zero is skipped. It is neither strobed nor counted.
- R9: `err_o` pulses one cycle after the end beat of a memory write when fewer payload dwords than declared have arrived. This includes a packet that ends during its header.
- R10: A packet with any other type byte produces no header or payload strobes. `drop_o` pulses one cycle after its end beat.
- R11: A cycle with `valid_i` low has no effect, whatever the other inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Beat qualifier |
| sop_i | input | 1 | First beat of a packet |
| eop_i | input | 1 | Last beat of a packet |
| be_i | input | 8 | Byte enables, bit k covers data byte k |
| data_i | input | 64 | Beat data |
| hdr_valid_o | output | 1 | Header fields valid (one-cycle pulse) |
| addr_o | output | 64 | Decoded byte address |
| len_o | output | LEN_W | Raw length field in dwords |
| first_be_o | output | 4 | First-dword byte enables |
| last_be_o | output | 4 | Last-dword byte enables |
| req_id_o | output | 16 | Requester ID |
| tag_o | output | 8 | Tag |
| pl_dv_o | output | 2 | Per-lane payload strobe, lane 0 = bits [31:0] |
| pl_data_o | output | 64 | Payload beat |
| err_o | output | 1 | Packet ended short of its declared length |
| drop_o | output | 1 | Non-write packet discarded |

## Verification
Every result is registered exactly once. Header fields, payload lanes, the error strobe and the drop strobe therefore appear one cycle after the input beat that produced them, and an idle cycle never produces a result. The bench drives beats on the falling edge and records outputs on the falling edge half a period after the rising edge that updates them. After each packet it waits out a few idle cycles before comparing the recorded header, payload sequence and strobe counts with values built from the sent packet. The sweep covers both header sizes, both values of address bit 2, a range of lengths with idle gaps between beats, truncated packets, the 1024-dword length, zero-enable lanes and several non-write types.

// File: rtl/tlp_mwr_pkg.sv
package tlp_mwr_pkg;
  localparam logic [7:0] FT_MWR_3DW = 8'h40;
  localparam logic [7:0] FT_MWR_4DW = 8'h60;
  localparam int DW_W  = 32;
  localparam int LANES = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR3,
    ST_HDR4,
    ST_DATA,
    ST_DROP
  } prs_state_e;
endpackage

// File: rtl/tlp_hdr_fields.sv
module tlp_hdr_fields
  import tlp_mwr_pkg::*;
#(
  parameter int LEN_W = 10,
  parameter int CNT_W = LEN_W + 1
) (
  input  logic [DW_W-1:0]  dw0_i,
  input  logic [DW_W-1:0]  dw1_i,
  output logic             is_mwr_o,
  output logic             is_4dw_o,
  output logic [LEN_W-1:0] len_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [15:0]      req_id_o,
  output logic [7:0]       tag_o,
  output logic [3:0]       fbe_o,
  output logic [3:0]       lbe_o
);
  logic [7:0] ft;

  always_comb begin
    ft       = dw0_i[31:24];
    is_mwr_o = (ft == FT_MWR_3DW) || (ft == FT_MWR_4DW);
    is_4dw_o = (ft == FT_MWR_4DW);
    len_o    = dw0_i[LEN_W-1:0];
    // zero length encodes the maximum
    cnt_o    = (len_o == '0) ? (CNT_W'(1) << LEN_W) : CNT_W'(len_o);
    req_id_o = dw1_i[31:16];
    tag_o    = dw1_i[15:8];
    lbe_o    = dw1_i[7:4];
    fbe_o    = dw1_i[3:0];
  end
endmodule

// File: rtl/tlp_lane_strobe.sv
module tlp_lane_strobe #(
  parameter int LANES = 2,
  parameter int CNT_W = 11
) (
  input  logic [LANES-1:0] cand_i,
  input  logic [CNT_W-1:0] rem_i,
  output logic [LANES-1:0] dv_o,
  output logic [CNT_W-1:0] take_o
);
  logic [CNT_W-1:0] acc [0:LANES];

  assign acc[0] = '0;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    // lane k is taken only if dwords remain after lower lanes
    assign dv_o[k]   = cand_i[k] && (rem_i > acc[k]);
    assign acc[k+1]  = acc[k] + CNT_W'(dv_o[k]);
  end

  assign take_o = acc[LANES];
endmodule

// File: rtl/tlp_mwr_parser.sv
module tlp_mwr_parser
  import tlp_mwr_pkg::*;
#(
  parameter int LEN_W = 10
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic                    sop_i,
  input  logic                    eop_i,
  input  logic [LANES*4-1:0]      be_i,
  input  logic [LANES*DW_W-1:0]   data_i,
  output logic                    hdr_valid_o,
  output logic [63:0]             addr_o,
  output logic [LEN_W-1:0]        len_o,
  output logic [3:0]              first_be_o,
  output logic [3:0]              last_be_o,
  output logic [15:0]             req_id_o,
  output logic [7:0]              tag_o,
  output logic [LANES-1:0]        pl_dv_o,
  output logic [LANES*DW_W-1:0]   pl_data_o,
  output logic                    err_o,
  output logic                    drop_o
);
  localparam int CNT_W = LEN_W + 1;

  prs_state_e       st_q;
  logic [CNT_W-1:0] rem_q, rem_next, take;
  logic [LANES-1:0] be_nz, cand, dv;

  logic             f_mwr, f_4dw;
  logic [LEN_W-1:0] f_len;
  logic [CNT_W-1:0] f_cnt;
  logic [15:0]      f_req;
  logic [7:0]       f_tag;
  logic [3:0]       f_fbe, f_lbe;

  tlp_hdr_fields #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_hdr (
    .dw0_i    (data_i[DW_W-1:0]),
    .dw1_i    (data_i[2*DW_W-1:DW_W]),
    .is_mwr_o (f_mwr),
    .is_4dw_o (f_4dw),
    .len_o    (f_len),
    .cnt_o    (f_cnt),
    .req_id_o (f_req),
    .tag_o    (f_tag),
    .fbe_o    (f_fbe),
    .lbe_o    (f_lbe)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_benz
    assign be_nz[k] = |be_i[4*k +: 4];
  end

  always_comb begin
    cand = '0;
    if (valid_i) begin
      unique case (st_q)
        // unaligned 3DW write: first dword rides in the upper lane
        ST_HDR3: cand = {be_nz[1] & data_i[2], 1'b0};
        ST_DATA: cand = be_nz;
        default: cand = '0;
      endcase
    end
  end

  tlp_lane_strobe #(.LANES(LANES), .CNT_W(CNT_W)) u_lane (
    .cand_i (cand),
    .rem_i  (rem_q),
    .dv_o   (dv),
    .take_o (take)
  );

  assign rem_next = rem_q - take;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      rem_q       <= '0;
      hdr_valid_o <= 1'b0;
      addr_o      <= '0;
      len_o       <= '0;
      first_be_o  <= '0;
      last_be_o   <= '0;
      req_id_o    <= '0;
      tag_o       <= '0;
      pl_dv_o     <= '0;
      pl_data_o   <= '0;
      err_o       <= 1'b0;
      drop_o      <= 1'b0;
    end else begin
      hdr_valid_o <= 1'b0;
      err_o       <= 1'b0;
      drop_o      <= 1'b0;
      pl_dv_o     <= dv;
      if (valid_i) begin
        pl_data_o <= data_i;
        unique case (st_q)
          ST_IDLE: begin
            if (sop_i) begin
              if (f_mwr) begin
                len_o      <= f_len;
                first_be_o <= f_fbe;
                last_be_o  <= f_lbe;
                req_id_o   <= f_req;
                tag_o      <= f_tag;
                rem_q      <= f_cnt;
                if (eop_i) err_o <= 1'b1;
                else       st_q  <= f_4dw ? ST_HDR4 : ST_HDR3;
              end else if (eop_i) begin
                drop_o <= 1'b1;
              end else begin
                st_q <= ST_DROP;
              end
            end
          end
          ST_HDR3, ST_HDR4: begin
            addr_o <= (st_q == ST_HDR4)
                      ? {data_i[31:0], data_i[63:34], 2'b00}
                      : {32'h0, data_i[31:2], 2'b00};
            hdr_valid_o <= 1'b1;
            rem_q       <= rem_next;
            if (eop_i) begin
              err_o <= (rem_next != '0);
              st_q  <= ST_IDLE;
            end else begin
              st_q  <= ST_DATA;
            end
          end
          ST_DATA: begin
            rem_q <= rem_next;
            if (eop_i) begin
              err_o <= (rem_next != '0);
              st_q  <= ST_IDLE;
            end
          end
          ST_DROP: begin
            if (eop_i) begin
              drop_o <= 1'b1;
              st_q   <= ST_IDLE;
            end
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/tlp_mwr_parser_chk.sv
module tlp_mwr_parser_chk #(
  parameter int LEN_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic             eop_i,
  input logic             hdr_valid_o,
  input logic [LEN_W-1:0] len_o,
  input logic [1:0]       pl_dv_o,
  input logic             err_o,
  input logic             drop_o
);
  localparam int CntW = LEN_W + 1;

  logic [CntW-1:0] got_q, got_sum, lim;

  assign lim     = (len_o == '0) ? (CntW'(1) << LEN_W) : CntW'(len_o);
  assign got_sum = (hdr_valid_o ? '0 : got_q) + CntW'($countones(pl_dv_o));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) got_q <= '0;
    else         got_q <= got_sum;
  end

  assert_quiet_after_reset_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!hdr_valid_o && pl_dv_o == 2'b00 && !err_o && !drop_o));

  assert_hdr_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_valid_o |=> !hdr_valid_o);

  assert_no_excess_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pl_dv_o != 2'b00) |-> (got_sum <= lim));

  assert_err_after_eop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(valid_i && eop_i));

  assert_drop_after_eop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_o |-> ($past(valid_i && eop_i) && !hdr_valid_o && pl_dv_o == 2'b00 && !err_o));

  assert_stall_inert_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!hdr_valid_o && pl_dv_o == 2'b00 && !err_o && !drop_o));
endmodule

bind tlp_mwr_parser tlp_mwr_parser_chk #(.LEN_W(LEN_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_i     (valid_i),
  .eop_i       (eop_i),
  .hdr_valid_o (hdr_valid_o),
  .len_o       (len_o),
  .pl_dv_o     (pl_dv_o),
  .err_o       (err_o),
  .drop_o      (drop_o)
);

// File: tb/tlp_mwr_parser_tb_top.sv
module tlp_mwr_parser_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0, sop = 1'b0, eop = 1'b0;
  logic [7:0]  be = '0;
  logic [63:0] data = '0;
  logic        hdr_valid, err, drop;
  logic [63:0] addr, pl_data;
  logic [9:0]  len;
  logic [3:0]  fbe, lbe;
  logic [15:0] req_id;
  logic [7:0]  tag;
  logic [1:0]  pl_dv;

  always #10 clk = ~clk;

  tlp_mwr_parser dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .sop_i(sop), .eop_i(eop),
    .be_i(be), .data_i(data), .hdr_valid_o(hdr_valid), .addr_o(addr),
    .len_o(len), .first_be_o(fbe), .last_be_o(lbe), .req_id_o(req_id),
    .tag_o(tag), .pl_dv_o(pl_dv), .pl_data_o(pl_data), .err_o(err), .drop_o(drop)
  );

  int n_chk = 0, n_fail = 0;
  logic [31:0] rx_dw [0:1039];
  int rx_n = 0, hdr_n = 0, err_n = 0, drop_n = 0;
  logic [63:0] h_addr;
  logic [9:0]  h_len;
  logic [31:0] h_fld;

  always @(negedge clk) if (rst_n) begin
    if (hdr_valid) begin
      hdr_n++; h_addr = addr; h_len = len; h_fld = {req_id, tag, lbe, fbe};
    end
    if (pl_dv[0] && rx_n < 1040) begin rx_dw[rx_n] = pl_data[31:0];  rx_n++; end
    if (pl_dv[1] && rx_n < 1040) begin rx_dw[rx_n] = pl_data[63:32]; rx_n++; end
    if (err)  err_n++;
    if (drop) drop_n++;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pw(input int seed, input int i);
    return {16'(seed) ^ 16'hA5C3, 16'(i)};
  endfunction

  task automatic beat(input bit s, input bit e, input logic [7:0] b, input logic [63:0] d);
    @(negedge clk);
    valid = 1'b1; sop = s; eop = e; be = b; data = d;
  endtask

  // idle cycles carry junk on every other input (R11)
  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      valid = 1'b0; sop = 1'b1; eop = 1'b1; be = 8'hFF; data = 64'h4000_0001_DEAD_BEEF;
    end
  endtask

  task automatic flush();
    idle(3);
    #1;
  endtask

  task automatic clr();
    rx_n = 0; hdr_n = 0; err_n = 0; drop_n = 0;
  endtask

  logic [31:0] dq [0:1039];
  bit          de [0:1039];

  task automatic send_mwr(input bit four, input logic [63:0] a, input int len_f,
                          input int short_n, input int seed, input int gap_mod);
    int total, n, npl, bad, first_bad;
    logic [31:0] dw0, dw1;
    logic [63:0] exp_a;
    string rq;
    total = (len_f == 0) ? 1024 : len_f;
    npl   = total - short_n;
    dw0   = {four ? 8'h60 : 8'h40, 14'h0, 10'(len_f)};
    dw1   = {16'(seed * 7 + 3), 8'(seed + 1), 4'(seed), 4'hF};
    clr();
    dq[0] = dw0; de[0] = 1; dq[1] = dw1; de[1] = 1;
    if (four) begin
      dq[2] = a[63:32]; de[2] = 1; dq[3] = a[31:0]; de[3] = 1; n = 4;
    end else begin
      dq[2] = a[31:0]; de[2] = 1; n = 3;
      if (!a[2]) begin dq[3] = '0; de[3] = 0; n = 4; end
    end
    for (int i = 0; i < npl; i++) begin dq[n] = pw(seed, i); de[n] = 1; n++; end
    if (n % 2 == 1) begin dq[n] = '0; de[n] = 0; n++; end
    for (int b = 0; b < n / 2; b++) begin
      if (gap_mod > 0 && b % gap_mod == 1) idle(1);
      beat(b == 0, b == n / 2 - 1, {de[2*b+1] ? 4'hF : 4'h0, de[2*b] ? 4'hF : 4'h0},
           {dq[2*b+1], dq[2*b]});
    end
    flush();
    exp_a = four ? {a[63:2], 2'b00} : {32'h0, a[31:2], 2'b00};
    chk(hdr_n == 1, "R2 header strobe count", 64'(hdr_n), 64'd1);
    chk(h_len == 10'(len_f) && h_fld == dw1, "R2 header fields",
        {22'h0, h_len, h_fld}, {22'h0, 10'(len_f), dw1});
    chk(h_addr == exp_a, four ? "R6 address" : "R3 address", h_addr, exp_a);
    rq = four ? "R6 payload order" : (a[2] ? "R5 payload order" : "R4 payload order");
    chk(rx_n == npl, short_n > 0 ? "R9 payload count" :
        (gap_mod > 0 ? "R11 payload count with gaps" : "R7 payload count"),
        64'(rx_n), 64'(npl));
    bad = 0; first_bad = -1;
    for (int i = 0; i < npl && i < rx_n; i++)
      if (rx_dw[i] !== pw(seed, i)) begin bad++; if (first_bad < 0) first_bad = i; end
    chk(bad == 0, rq, (first_bad < 0) ? 64'h0 : 64'(rx_dw[first_bad]),
        (first_bad < 0) ? 64'h0 : 64'(pw(seed, first_bad)));
    chk(err_n == (short_n > 0 ? 1 : 0), "R9 short-packet error", 64'(err_n),
        64'(short_n > 0 ? 1 : 0));
    chk(drop_n == 0, "R10 no drop on write", 64'(drop_n), 64'd0);
  endtask

  task automatic send_other(input logic [7:0] ft, input int nb);
    clr();
    for (int b = 0; b < nb; b++)
      beat(b == 0, b == nb - 1, 8'hFF,
           (b == 0) ? {32'h0001_020F, ft, 24'h000004} : {32'h1111_0000 + 32'(b), 32'h0000_2004});
    flush();
    chk(drop_n == 1, "R10 drop strobe", 64'(drop_n), 64'd1);
    chk(hdr_n == 0 && rx_n == 0 && err_n == 0, "R10 no other strobes",
        64'(hdr_n + rx_n + err_n), 64'd0);
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(!hdr_valid && pl_dv == 2'b00 && !err && !drop, "R1 reset outputs",
        {60'h0, hdr_valid, pl_dv == 2'b00, err, drop}, 64'h4);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    chk(!hdr_valid && pl_dv == 2'b00 && !err && !drop, "R1 first cycle after reset",
        {60'h0, hdr_valid, pl_dv == 2'b00, err, drop}, 64'h4);

    // sweep: header size x address bit 2 x length, some with idle gaps
    for (int f = 0; f < 2; f++)
      for (int al = 0; al < 2; al++)
        for (int l = 1; l <= 6; l++) begin
          int sd;
          sd = f * 40 + al * 10 + l;
          send_mwr(f[0], {32'h0000_0012 + 32'(sd), 32'h8000_1000 + 32'(al * 4) + 32'(sd * 16) + 32'(sd % 2 * 3)},
                   l, 0, sd, l % 3);
        end

    // truncated writes (R9)
    send_mwr(1'b0, 64'h0000_0000_0000_2000, 4, 1, 91, 0);
    send_mwr(1'b0, 64'h0000_0000_0000_2004, 5, 2, 92, 0);
    send_mwr(1'b1, 64'h0000_0003_0000_2000, 3, 3, 93, 0);
    send_mwr(1'b0, 64'h0000_0000_0000_2004, 1, 1, 94, 0);
    clr();
    beat(1'b1, 1'b1, 8'hFF, {32'h0001_000F, 32'h4000_0002});
    flush();
    chk(err_n == 1 && hdr_n == 0, "R9 eop during header", 64'(err_n * 2 + hdr_n), 64'd2);

    // maximum length encoded as zero (R7)
    send_mwr(1'b0, 64'h0000_0000_0001_0000, 0, 0, 95, 0);

    // excess data beyond declared length (R7)
    clr();
    beat(1'b1, 1'b0, 8'hFF, {32'h00AB_CD0F, 32'h4000_0002});
    beat(1'b0, 1'b0, 8'h0F, {32'h0, 32'h0000_3000});
    beat(1'b0, 1'b0, 8'hFF, {pw(96, 1), pw(96, 0)});
    beat(1'b0, 1'b1, 8'hFF, {32'hBAD0_0001, 32'hBAD0_0000});
    flush();
    chk(rx_n == 2 && err_n == 0, "R7 excess dwords not strobed", 64'(rx_n), 64'd2);

    // zero-enable lane skipped (R8)
    clr();
    beat(1'b1, 1'b0, 8'hFF, {32'h00AB_CD0F, 32'h4000_0003});
    beat(1'b0, 1'b0, 8'h0F, {32'h0, 32'h0000_3000});
    beat(1'b0, 1'b0, 8'hF0, {pw(97, 0), 32'hBAD0_0000});
    beat(1'b0, 1'b0, 8'h00, {32'hBAD0_0002, 32'hBAD0_0001});
    beat(1'b0, 1'b1, 8'hFF, {pw(97, 2), pw(97, 1)});
    flush();
    chk(rx_n == 3 && err_n == 0, "R8 zero-enable lane count", 64'(rx_n), 64'd3);
    chk(rx_dw[0] == pw(97, 0) && rx_dw[1] == pw(97, 1) && rx_dw[2] == pw(97, 2),
        "R8 zero-enable lane data", 64'(rx_dw[1]), 64'(pw(97, 1)));

    // non-write packets (R10)
    send_other(8'h00, 3);
    send_other(8'h4A, 2);
    send_other(8'h20, 1);
    send_other(8'h44, 4);

    // a write still parses after drops
    send_mwr(1'b1, 64'h0000_00FF_0000_0104, 2, 0, 98, 2);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule